// File: doc/BRIEF.md
# Feedback Divider Ramp Sequencer

This block changes the feedback divider N of a PLL that is already running, without losing lock. It does so by driving the PLL's own dynamic ramp hardware. After a request with a new N, it loads the two step-rate fields and turns on slowdown mode. It then writes the new N into the coefficient field and enables the ramp. From that point it polls a synchronised ramp-done status until the status is seen or a poll limit is used up. At the end it leaves slowdown mode and reports the result as a one-cycle done pulse with an error bit.

The time between polls comes from a programmable prescaler: one poll every `poll_div_i + 1` clock cycles. The caller supplies the N that is currently programmed. If that value equals the requested N, the request completes at once and no output field moves. A request that arrives while a ramp is under way is dropped.

Top module: `ndiv_ramp_ctrl`

## Requirements
- R1: If `n_target_i` equals `n_current_i` when a request is accepted, `done_o` is high in the next cycle with `err_o` = 0. `busy_o` stays low and no control field changes.
- R2: For an accepted request with a new N, edge E0 is the one that samples `start_i`. After E0 `busy_o` is high. After edge E1, `step_a_o` = 0x2B and `step_b_o` = 0x0B.
- R3: After E2, `slowdown_o` is 1. The new N appears on `coeff_n_o` only after E3, with a one-cycle `coeff_wr_o` pulse, so slowdown is already set when N is written.
- R4: `ramp_en_o` rises only after E4, which is the cycle after the N write. While it is high, `slowdown_o` is high too.
- R5: Polls take place at edges E4 + k·(`poll_div_i`+1), for k = 1, 2, … The first poll that sees `ramp_done_i` = 1 ends the operation at that edge, with `err_o` = 0.
- R6: At the end of an operation, `slowdown_o` and `ramp_en_o` fall in the same cycle as the one-cycle `done_o` pulse. This holds for both success and timeout.
- R7: If 500 polls pass without seeing done, the operation ends at the 500th poll with `err_o` = 1.
- R8: A `start_i` that arrives while `busy_o` is high is ignored. The coefficient field and the completion time of the ramp under way do not change.
- R9: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request pulse |
| n_target_i | input | 8 | Requested feedback divider |
| n_current_i | input | 8 | Feedback divider currently programmed |
| poll_div_i | input | 8 | Poll interval minus one, in cycles |
| ramp_done_i | input | 1 | Synchronised ramp-finished status |
| step_a_o | output | 8 | Ramp step-rate field A |
| step_b_o | output | 8 | Ramp step-rate field B |
| slowdown_o | output | 1 | Slowdown mode control |
| ramp_en_o | output | 1 | Dynamic ramp enable |
| coeff_n_o | output | 8 | Programmed N coefficient field |
| coeff_wr_o | output | 1 | Pulse when coeff_n_o is written |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout flag, valid with done_o |

## Verification
The hardest cases to reach are the edges of the poll window: done that arrives in time for the 500th poll, and done that misses it by one cycle. The bench plays the ramp hardware. It raises `ramp_done_i` a chosen number of cycles after the ramp is enabled, and it sweeps that delay through small values, through 498, 499 and 500 cycles, and through never. It repeats the sweep for several prescaler settings. The expected poll count and latency are worked out as a ceiling division on each run.

// File: rtl/ndiv_ramp_pkg.sv
// Shared types for the feedback divider ramp sequencer.
// Assumes: used by ndiv_ramp_ctrl only.
package ndiv_ramp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEP,
        ST_SLOW,
        ST_WRN,
        ST_RAMP,
        ST_POLL
    } ramp_state_e;
endpackage

// File: rtl/ramp_prescaler.sv
// Poll interval generator: gives one tick every div_i+1 cycles while not cleared.
// Assumes: div_i holds steady during an operation; clear_i high forces the count to zero.
module ramp_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic [W-1:0] div_i,
    output logic         tick_o
);
    logic [W-1:0] cnt_q;

    assign tick_o = !clear_i && (cnt_q == div_i);

    // Counts cycles up to div_i, then wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) cnt_q <= '0;
        else if (tick_o)       cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |-> cnt_q <= div_i);
endmodule

// File: rtl/ramp_poll_count.sv
// Poll counter: counts the polls that did not see done and flags the last permitted one.
// Assumes: step_i pulses only on a poll that did not see done; clear_i restarts the count.
module ramp_poll_count #(
    parameter int LIMIT = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    output logic last_o
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign last_o = (cnt_q == LAST);

    // Adds one for each poll that missed done; stops at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)       cnt_q <= '0;
        else if (step_i && !last_o)  cnt_q <= cnt_q + 1'b1;
    end

    p_poll_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/ndiv_ramp_ctrl.sv
// Feedback divider ramp sequencer.
// Loads the step fields, sets slowdown, writes N, enables the ramp, and then polls
// ramp_done_i at prescaled intervals up to POLL_LIMIT times. It then clears
// slowdown and ramp enable together and pulses done_o, with err_o set on timeout.
// Assumes: ramp_done_i is already synchronised to clk; n_current_i is the value in effect.
module ndiv_ramp_ctrl
    import ndiv_ramp_pkg::*;
#(
    parameter int N_W        = 8,
    parameter int STEP_W     = 8,
    parameter int PRESC_W    = 8,
    parameter int POLL_LIMIT = 500,
    parameter logic [STEP_W-1:0] STEP_A_VAL = STEP_W'('h2B),
    parameter logic [STEP_W-1:0] STEP_B_VAL = STEP_W'('h0B)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [N_W-1:0]     n_target_i,
    input  logic [N_W-1:0]     n_current_i,
    input  logic [PRESC_W-1:0] poll_div_i,
    input  logic               ramp_done_i,
    output logic [STEP_W-1:0]  step_a_o,
    output logic [STEP_W-1:0]  step_b_o,
    output logic               slowdown_o,
    output logic               ramp_en_o,
    output logic [N_W-1:0]     coeff_n_o,
    output logic               coeff_wr_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               err_o
);
    ramp_state_e       state_q;
    logic [N_W-1:0]    n_lat_q;
    logic [STEP_W-1:0] step_a_q, step_b_q;
    logic              slowdown_q, ramp_en_q, coeff_wr_q, done_q, err_q;
    logic [N_W-1:0]    coeff_n_q;
    logic              in_poll, tick, poll_last, poll_miss;

    assign in_poll   = (state_q == ST_POLL);
    assign poll_miss = tick && !ramp_done_i;

    ramp_prescaler #(.W(PRESC_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (!in_poll),
        .div_i   (poll_div_i),
        .tick_o  (tick)
    );

    ramp_poll_count #(.LIMIT(POLL_LIMIT)) u_polls (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (!in_poll),
        .step_i  (poll_miss),
        .last_o  (poll_last)
    );

    // Sequencer: one register action per state, ending on a done poll or on the last poll.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            n_lat_q    <= '0;
            step_a_q   <= '0;
            step_b_q   <= '0;
            slowdown_q <= 1'b0;
            ramp_en_q  <= 1'b0;
            coeff_n_q  <= '0;
            coeff_wr_q <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            done_q     <= 1'b0;
            coeff_wr_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (n_target_i == n_current_i) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b0;
                        end else begin
                            n_lat_q <= n_target_i;
                            state_q <= ST_STEP;
                        end
                    end
                end
                ST_STEP: begin
                    step_a_q <= STEP_A_VAL;
                    step_b_q <= STEP_B_VAL;
                    state_q  <= ST_SLOW;
                end
                ST_SLOW: begin
                    slowdown_q <= 1'b1;
                    state_q    <= ST_WRN;
                end
                ST_WRN: begin
                    coeff_n_q  <= n_lat_q;
                    coeff_wr_q <= 1'b1;
                    state_q    <= ST_RAMP;
                end
                ST_RAMP: begin
                    ramp_en_q <= 1'b1;
                    state_q   <= ST_POLL;
                end
                ST_POLL: begin
                    if (tick && (ramp_done_i || poll_last)) begin
                        slowdown_q <= 1'b0;
                        ramp_en_q  <= 1'b0;
                        done_q     <= 1'b1;
                        err_q      <= !ramp_done_i;
                        state_q    <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign step_a_o   = step_a_q;
    assign step_b_o   = step_b_q;
    assign slowdown_o = slowdown_q;
    assign ramp_en_o  = ramp_en_q;
    assign coeff_n_o  = coeff_n_q;
    assign coeff_wr_o = coeff_wr_q;
    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = done_q;
    assign err_o      = err_q;

    p_steps_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        slowdown_q |-> (step_a_q == STEP_A_VAL) && (step_b_q == STEP_B_VAL));
    p_slow_before_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        coeff_wr_q |-> slowdown_q && !ramp_en_q);
    p_en_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ramp_en_q) |-> $past(coeff_wr_q));
    p_en_needs_slow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_en_q |-> slowdown_q);
    p_clear_together_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slowdown_q) |-> $fell(ramp_en_q) && done_q);
    p_timeout_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && err_q) |-> $past(poll_last) && !$past(ramp_done_i));
endmodule

// File: tb/ndiv_ramp_ctrl_test.sv
module ndiv_ramp_ctrl_test;
    localparam int LIMIT = 500;
    localparam int NEVER = 1 << 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] n_target_i = '0;
    logic [7:0] n_current_i = '0;
    logic [7:0] poll_div_i = '0;
    logic       ramp_done_i = 1'b0;
    logic [7:0] step_a_o, step_b_o, coeff_n_o;
    logic       slowdown_o, ramp_en_o, coeff_wr_o, busy_o, done_o, err_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    ndiv_ramp_ctrl uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .n_target_i(n_target_i),
        .n_current_i(n_current_i), .poll_div_i(poll_div_i), .ramp_done_i(ramp_done_i),
        .step_a_o(step_a_o), .step_b_o(step_b_o), .slowdown_o(slowdown_o),
        .ramp_en_o(ramp_en_o), .coeff_n_o(coeff_n_o), .coeff_wr_o(coeff_wr_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    // One ramp. The model raises done dly cycles after the ramp enable; busy_at pulses start mid-run.
    task automatic run_ramp(input int p, input int dly, input logic [7:0] tgt, input int busy_at);
        int k, exp_lat, lat;
        bit exp_err;
        logic [7:0] old_n;
        old_n = coeff_n_o;
        k = (dly + 1 + p) / (p + 1);
        exp_err = (k > LIMIT);
        if (exp_err) k = LIMIT;
        exp_lat = 4 + k * (p + 1);
        lat = -1;
        @(negedge clk);
        poll_div_i = 8'(p);
        n_target_i = tgt;
        n_current_i = old_n;
        start_i = 1'b1;
        for (int e = 0; e <= exp_lat + 2; e++) begin
            @(negedge clk);
            start_i = (e + 1 == busy_at);
            if (start_i) n_target_i = tgt ^ 8'h5A;
            ramp_done_i = (e >= 4 + dly) && (dly < NEVER);
            if (e == 0) chk(busy_o == 1'b1, "R2 busy", busy_o, 1);
            if (e == 1) begin
                chk(step_a_o == 8'h2B, "R2 stepA", step_a_o, 'h2B);
                chk(step_b_o == 8'h0B, "R2 stepB", step_b_o, 'h0B);
                chk(slowdown_o == 1'b0, "R3 slow early", slowdown_o, 0);
            end
            if (e == 2) begin
                chk(slowdown_o == 1'b1, "R3 slow set", slowdown_o, 1);
                chk(coeff_n_o == old_n, "R3 N not yet", coeff_n_o, old_n);
            end
            if (e == 3) begin
                chk(coeff_n_o == tgt && coeff_wr_o, "R3 N written", coeff_n_o, tgt);
                chk(ramp_en_o == 1'b0, "R4 en early", ramp_en_o, 0);
            end
            if (e == 4) chk(ramp_en_o == 1'b1, "R4 en set", ramp_en_o, 1);
            if (e > 4 && busy_at > 0 && lat < 0)
                chk(coeff_n_o == tgt, "R8 N kept", coeff_n_o, tgt);
            if (done_o && lat < 0) begin
                lat = e;
                chk(err_o == exp_err, exp_err ? "R7 timeout err" : "R5 ok err", err_o, exp_err);
                chk(!slowdown_o && !ramp_en_o, "R6 cleared", {slowdown_o, ramp_en_o}, 0);
            end
            if (e == exp_lat + 1) begin
                chk(done_o == 1'b0, "R6 one pulse", done_o, 0);
                chk(busy_o == 1'b0, "R8 idle after", busy_o, 0);
            end
        end
        chk(lat == exp_lat, exp_err ? "R7 latency" : "R5 latency", lat, exp_lat);
        ramp_done_i = 1'b0;
        start_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Same-N request: done at once, nothing moves.
    task automatic run_same();
        logic [7:0] sa, sb, cn;
        sa = step_a_o; sb = step_b_o; cn = coeff_n_o;
        @(negedge clk);
        n_target_i = coeff_n_o;
        n_current_i = coeff_n_o;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o && !err_o, "R1 done at once", {done_o, err_o}, 2);
        chk(!busy_o, "R1 not busy", busy_o, 0);
        @(negedge clk);
        chk(!done_o && !slowdown_o && !ramp_en_o, "R1 no ramp", {done_o, slowdown_o, ramp_en_o}, 0);
        chk(step_a_o == sa && step_b_o == sb && coeff_n_o == cn, "R1 fields kept",
            coeff_n_o, cn);
    endtask

    initial begin
        int pl[3];
        int dl[6];
        logic [7:0] t;
        pl = '{0, 1, 3};
        dl = '{0, 1, 2, 3, 7, 20};
        repeat (3) @(negedge clk);
        chk({step_a_o, step_b_o, coeff_n_o, slowdown_o, ramp_en_o, coeff_wr_o,
             busy_o, done_o, err_o} == '0, "R9 reset", coeff_n_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o, "R9 idle", busy_o, 0);
        run_same();
        t = 8'h11;
        foreach (pl[i]) begin
            foreach (dl[j]) begin
                run_ramp(pl[i], dl[j], t, 0);
                t = t + 8'd37;
            end
            run_ramp(pl[i], NEVER, t, 0);
            t = t + 8'd37;
            run_same();
        end
        run_ramp(0, 498, t, 0); t = t + 8'd37;
        run_ramp(0, 499, t, 0); t = t + 8'd37;
        run_ramp(0, 500, t, 0); t = t + 8'd37;
        run_ramp(1, 30, t, 12); t = t + 8'd37;
        run_ramp(2, NEVER, t, 40);
        run_same();
        finish_run();
    end
endmodule